// File: doc/BRIEF.md
# Dual Mode Interval Timer Pair

This block holds two 16-bit down-counters for a small 8-bit peripheral adapter. Software reaches them over a plain register bus with a 3-bit address, separate write and read strobes and 8-bit data. The first counter, unit A, measures a single interval or runs free with an automatic reload. It can also drive a single low pulse or a square wave onto a port output bit. The second counter, unit B, measures a single interval or counts falling edges seen on a port input bit. Each counter raises a timeout flag. The interrupt line is the OR of the flags that software has enabled.

Software loads a counter in two steps. It writes the low byte into a holding byte. It then writes the high byte, and that write moves the full 16-bit value into the counter, starts the counter and clears its flag. The behaviour of both units is chosen by a shared mode register. Each unit is built as a three-state machine. TMR_IDLE is the state after reset, and the counter holds. TMR_ARMED is entered by a load: it counts and will raise the flag. TMR_SPENT is entered when a one-shot has expired: it keeps counting but raises no flag. The transitions are: IDLE to ARMED and SPENT to ARMED on a high-byte write; ARMED to SPENT on the first one-shot expiry; ARMED to ARMED again on a repeated load. Unit A in free-running mode stays in its current state at every underflow.

Register offsets: 0 reads the unit A count low byte and writes its holding byte. 1 reads the unit A count high byte, and a write loads unit A. Offsets 2 and 3 do the same for unit B. 4 is the mode register. 5 is the interrupt enable register (bit 0 unit A, bit 1 unit B). 6 is the read-only flag register (bit 0 unit A, bit 1 unit B). Offset 7 reads 0.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts read 0, the flag register reads 0, the mode register reads 0, irq is 0 and pulse_out is 1.
- R2: A write to offset 0 or 2 changes only the holding byte and leaves the count unchanged. A write of value H to offset 1 or 3 puts H*256 + holding byte into that count on the write edge, clears that flag and enters TMR_ARMED. Reads of offsets 0 to 3 return the live count bytes.
- R3: With mode bit 6 clear, unit A loaded with N decrements once per clock. Its flag is set on the edge N+1 cycles after the load edge. The count then wraps to 0xFFFF and keeps decrementing, and no further flag is raised until the next load.
- R4: With mode bit 6 set, unit A reloads its last loaded 16-bit value at every underflow and sets its flag there, giving a period of N+1 cycles.
- R5: With mode bit 7 set and bit 6 clear, pulse_out goes to 0 on the load edge and returns to 1 on the expiry edge.
- R6: With mode bits 7 and 6 both set, pulse_out goes to 0 on the load edge and toggles at every underflow. With mode bit 7 clear, pulse_out is held at 1.
- R7: With mode bit 5 clear, unit B behaves as a one-shot like R3. Mode bit 6 has no effect on unit B, so unit B never reloads.
- R8: With mode bit 5 set, unit B decrements only on a falling edge of edge_pin, three clock edges after the pin change; rising edges do nothing. Its flag is set when the count steps from 1 to 0 while TMR_ARMED.
- R9: A read strobe at offset 0 (unit A) or offset 2 (unit B) clears that flag, but a flag being set on the same edge wins over the clear. Reads of other offsets clear nothing.
- R10: irq equals (flag A and enable bit 0) or (flag B and enable bit 1). Masked flags stay visible in the flag register.
- R11: A high-byte write on the same edge as an underflow loads the new value, and the flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| edge_pin | input | 1 | Port input bit counted by unit B |
| pulse_out | output | 1 | Port output bit driven by unit A |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the edge that samples the strobe. A load count and the flag-clear of a read are visible half a cycle later. Expiry is due N+1 edges after the load, and a counted pin fall is due on the third edge after the pin changes. Read data and irq are combinational from the register state. The bench keeps a behavioural model that steps on every rising edge and compares rdata, irq and pulse_out 1 ns later. The directed checks sample at falling edges, placed by counting edges from the write strobe to each expected result.

// File: rtl/dit_pkg.sv
package dit_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_ARMED = 2'd1,
        TMR_SPENT = 2'd2
    } tmr_state_e;

    localparam logic [2:0] OFS_A_LO  = 3'd0;
    localparam logic [2:0] OFS_A_HI  = 3'd1;
    localparam logic [2:0] OFS_B_LO  = 3'd2;
    localparam logic [2:0] OFS_B_HI  = 3'd3;
    localparam logic [2:0] OFS_MODE  = 3'd4;
    localparam logic [2:0] OFS_IEN   = 3'd5;
    localparam logic [2:0] OFS_FLAGS = 3'd6;

    localparam int MODE_OUT_EN  = 7;
    localparam int MODE_A_FREE  = 6;
    localparam int MODE_B_PULSE = 5;
endpackage

// File: rtl/dit_sync_fall.sv
module dit_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] chain_q;

    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign fall = chain_q[TAPS-1] & ~chain_q[TAPS-2];
endmodule

// File: rtl/dit_timer_a.sv
module dit_timer_a
    import dit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             freerun,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             level
);
    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, reload_q;
    logic             flag_q, flag_d, lvl_q, lvl_d, set_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= TMR_IDLE;
            cnt_q    <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
            lvl_q    <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            lvl_q  <= lvl_d;
            if (load) reload_q <= load_val;
        end
    end

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        flag_d  = flag_q;
        lvl_d   = lvl_q;
        set_now = 1'b0;
        if (load) begin
            cnt_d  = load_val;
            st_d   = TMR_ARMED;
            flag_d = 1'b0;
            lvl_d  = 1'b0;
        end else begin
            unique case (st_q)
                TMR_IDLE: begin
                    cnt_d = cnt_q;
                end
                TMR_ARMED, TMR_SPENT: begin
                    if (cnt_q == '0) begin
                        if (freerun) begin
                            cnt_d   = reload_q;
                            set_now = 1'b1;
                            lvl_d   = ~lvl_q;
                        end else begin
                            cnt_d = '1;
                            if (st_q == TMR_ARMED) begin
                                set_now = 1'b1;
                                lvl_d   = 1'b1;
                                st_d    = TMR_SPENT;
                            end
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: st_d = TMR_IDLE;
            endcase
            if (clr_req) flag_d = 1'b0;
            if (set_now) flag_d = 1'b1;
        end
    end

    assign cnt   = cnt_q;
    assign flag  = flag_q;
    assign level = lvl_q;

    // R2
    a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)) && !flag_q && (st_q == TMR_ARMED));
    // R3
    a_oneshot_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TMR_ARMED && cnt_q == '0 && !load && !freerun) |=> flag_q && lvl_q && (st_q == TMR_SPENT));
    // R4
    a_freerun_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TMR_IDLE && cnt_q == '0 && !load && freerun) |=> (cnt_q == $past(reload_q)) && flag_q);
endmodule

// File: rtl/dit_timer_b.sv
module dit_timer_b
    import dit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pulse_mode,
    input  logic             fall,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d, tick, hit, set_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TMR_IDLE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        tick    = pulse_mode ? fall : 1'b1;
        hit     = pulse_mode ? (cnt_q == ONE) : (cnt_q == '0);
        st_d    = st_q;
        cnt_d   = cnt_q;
        flag_d  = flag_q;
        set_now = 1'b0;
        if (load) begin
            cnt_d  = load_val;
            st_d   = TMR_ARMED;
            flag_d = 1'b0;
        end else begin
            unique case (st_q)
                TMR_IDLE: begin
                    cnt_d = cnt_q;
                end
                TMR_ARMED: begin
                    if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                        if (hit) begin
                            set_now = 1'b1;
                            st_d    = TMR_SPENT;
                        end
                    end
                end
                TMR_SPENT: begin
                    if (tick) cnt_d = cnt_q - 1'b1;
                end
                default: st_d = TMR_IDLE;
            endcase
            if (clr_req) flag_d = 1'b0;
            if (set_now) flag_d = 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    // R8
    a_pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TMR_IDLE && pulse_mode && !fall && !load) |=> (cnt_q == $past(cnt_q)));
    // R8
    a_pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TMR_ARMED && pulse_mode && fall && cnt_q == ONE && !load) |=> flag_q && (cnt_q == '0));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              edge_pin,
    output logic              pulse_out,
    output logic              irq
);
    localparam int CNT_W = 2 * BUS_W;

    logic [BUS_W-1:0] a_lo_q, b_lo_q, mode_q, ien_q;
    logic [CNT_W-1:0] a_cnt, b_cnt;
    logic             a_flag, b_flag, a_lvl, b_fall;
    logic             a_load, b_load, a_clr, b_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_lo_q <= '0;
            b_lo_q <= '0;
            mode_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_A_LO: a_lo_q <= wdata;
                OFS_B_LO: b_lo_q <= wdata;
                OFS_MODE: mode_q <= wdata;
                OFS_IEN:  ien_q  <= wdata;
                default:  ;
            endcase
        end
    end

    assign a_load = wr_en && (addr == OFS_A_HI);
    assign b_load = wr_en && (addr == OFS_B_HI);
    assign a_clr  = rd_en && (addr == OFS_A_LO);
    assign b_clr  = rd_en && (addr == OFS_B_LO);

    dit_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(edge_pin), .fall(b_fall)
    );

    dit_timer_a #(.CNT_W(CNT_W)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .load(a_load), .load_val({wdata, a_lo_q}),
        .freerun(mode_q[MODE_A_FREE]), .clr_req(a_clr),
        .cnt(a_cnt), .flag(a_flag), .level(a_lvl)
    );

    dit_timer_b #(.CNT_W(CNT_W)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .load(b_load), .load_val({wdata, b_lo_q}),
        .pulse_mode(mode_q[MODE_B_PULSE]), .fall(b_fall), .clr_req(b_clr),
        .cnt(b_cnt), .flag(b_flag)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_A_LO:  rdata = a_cnt[BUS_W-1:0];
            OFS_A_HI:  rdata = a_cnt[CNT_W-1:BUS_W];
            OFS_B_LO:  rdata = b_cnt[BUS_W-1:0];
            OFS_B_HI:  rdata = b_cnt[CNT_W-1:BUS_W];
            OFS_MODE:  rdata = mode_q;
            OFS_IEN:   rdata = ien_q;
            OFS_FLAGS: rdata = {{(BUS_W-2){1'b0}}, b_flag, a_flag};
            default:   rdata = '0;
        endcase
    end

    assign pulse_out = mode_q[MODE_OUT_EN] ? a_lvl : 1'b1;
    assign irq       = (a_flag & ien_q[0]) | (b_flag & ien_q[1]);

    // R2
    a_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_A_HI) |=> (a_cnt == {$past(wdata), $past(a_lo_q)}));
    // R9
    b_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_B_LO && !wr_en && !b_fall && !mode_q[MODE_B_PULSE] && b_cnt != '0) |=> !b_flag);
endmodule

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       edge_pin = 1'b1;
    logic       pulse_out, irq;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .edge_pin(edge_pin),
        .pulse_out(pulse_out), .irq(irq)
    );

    // behavioural reference
    int m_acnt, m_alo, m_arel, m_ast, m_bcnt, m_blo, m_bst;
    int m_mode, m_ien;
    bit m_aflag, m_alvl, m_bflag;
    bit m_p0, m_p1, m_p2;

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_acnt % 256;
            1: return m_acnt / 256;
            2: return m_bcnt % 256;
            3: return m_bcnt / 256;
            4: return m_mode;
            5: return m_ien;
            6: return (m_bflag ? 2 : 0) + (m_aflag ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit a_set, b_set, fall, tick, hit;
        int a;
        if (!rst_n) begin
            m_acnt = 0; m_alo = 0; m_arel = 0; m_ast = 0; m_bcnt = 0; m_blo = 0; m_bst = 0;
            m_mode = 0; m_ien = 0; m_aflag = 0; m_alvl = 1; m_bflag = 0;
            m_p0 = 1; m_p1 = 1; m_p2 = 1;
        end else begin
            a = addr;
            fall = m_p2 && !m_p1;
            a_set = 0; b_set = 0;
            if (wr_en && a == 1) begin
                m_acnt = wdata * 256 + m_alo; m_arel = m_acnt; m_ast = 1; m_aflag = 0; m_alvl = 0;
            end else begin
                if (m_ast != 0) begin
                    if (m_acnt == 0) begin
                        if (m_mode[6]) begin m_acnt = m_arel; a_set = 1; m_alvl = !m_alvl; end
                        else begin
                            m_acnt = 65535;
                            if (m_ast == 1) begin a_set = 1; m_alvl = 1; m_ast = 2; end
                        end
                    end else m_acnt = m_acnt - 1;
                end
                if (rd_en && a == 0) m_aflag = 0;
                if (a_set) m_aflag = 1;
            end
            if (wr_en && a == 3) begin
                m_bcnt = wdata * 256 + m_blo; m_bst = 1; m_bflag = 0;
            end else begin
                tick = m_mode[5] ? fall : 1;
                hit = m_mode[5] ? (m_bcnt == 1) : (m_bcnt == 0);
                if (m_bst != 0 && tick) begin
                    if (m_bst == 1 && hit) begin b_set = 1; m_bst = 2; end
                    m_bcnt = (m_bcnt + 65535) % 65536;
                end
                if (rd_en && a == 2) m_bflag = 0;
                if (b_set) m_bflag = 1;
            end
            if (wr_en && a == 0) m_alo = wdata;
            if (wr_en && a == 2) m_blo = wdata;
            if (wr_en && a == 4) m_mode = wdata;
            if (wr_en && a == 5) m_ien = wdata;
            m_p2 = m_p1; m_p1 = m_p0; m_p0 = edge_pin;
            #1;
            check("R2 model rdata", rdata, exp_rdata(a));
            check("R10 model irq", irq, (m_aflag && m_ien[0]) || (m_bflag && m_ien[1]));
            check("R6 model pulse_out", pulse_out, m_mode[7] ? m_alvl : 1);
        end
    end

    task automatic wr(int a, int d);
        addr = a[2:0]; wdata = d[7:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(string tag, int a, int exp, bit clr);
        addr = a[2:0]; rd_en = clr;
        #1;
        check(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin_fall();
        edge_pin = 1'b0;
        repeat (4) @(negedge clk);
        edge_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int toggles;
        bit prev, all_hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 irq", irq, 0);
        check("R1 pulse_out", pulse_out, 1);
        look("R1 flags", 6, 0, 0);
        look("R1 count", 0, 0, 0);
        look("R1 mode", 4, 0, 0);

        // R3 R5: one-shot with output
        wr(5, 3);
        wr(4, 8'h80);
        wr(0, 5);
        look("R2 low write keeps count", 0, 0, 0);
        wr(1, 0);
        check("R5 low on load", pulse_out, 0);
        look("R2 loaded count", 0, 5, 0);
        repeat (4) @(negedge clk);
        check("R3 no flag yet", irq, 0);
        check("R5 still low", pulse_out, 0);
        @(negedge clk);
        check("R3 flag at N+1", irq, 1);
        check("R5 high at expiry", pulse_out, 1);
        repeat (20) @(negedge clk);
        look("R3 single flag", 6, 1, 0);
        look("R3 wrapped high byte", 1, 255, 0);
        look("R9 read low", 0, exp_rdata(0), 1);
        check("R9 irq cleared", irq, 0);
        look("R9 flag cleared", 6, 0, 0);

        // R4 R6: free-run with output
        wr(4, 8'hC0);
        wr(0, 3);
        wr(1, 0);
        toggles = 0; prev = pulse_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pulse_out != prev) toggles++;
            prev = pulse_out;
        end
        check("R6 toggles in 40 cycles", toggles, 10);
        look("R4 flag set", 6, 1, 0);
        wr(4, 8'h40);
        all_hi = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pulse_out != 1'b1) all_hi = 0;
        end
        check("R6 output disabled", all_hi, 1);

        // R10 masking
        wr(5, 2);
        repeat (8) @(negedge clk);
        check("R10 masked irq", irq, 0);
        look("R10 flag visible", 6, 1, 0);
        wr(5, 1);
        check("R10 enabled irq", irq, 1);

        // R11 load wins over underflow
        wr(4, 0);
        wr(0, 1);
        wr(1, 0);
        @(negedge clk);
        wr(1, 2);
        look("R11 new low byte", 0, 1, 0);
        look("R11 flag cleared", 6, 0, 0);

        // R9 set wins over clear
        wr(0, 2);
        wr(1, 0);
        repeat (2) @(negedge clk);
        look("R9 read at expiry", 0, 0, 1);
        look("R9 set wins", 6, 1, 0);
        look("R9 clear", 0, exp_rdata(0), 1);
        look("R9 cleared", 6, 0, 0);

        // R7 unit B one-shot, mode bit 6 ignored
        wr(4, 8'h40);
        wr(2, 4);
        wr(3, 0);
        repeat (4) @(negedge clk);
        look("R7 no flag yet", 6, 0, 0);
        look("R7 flag at N+1", 6, 2, 0);
        repeat (3) @(negedge clk);
        look("R7 no reload", 3, 255, 0);
        look("R9 clear B", 2, exp_rdata(2), 1);
        look("R9 B cleared", 6, 0, 0);

        // R8 pulse counting
        wr(4, 8'h20);
        wr(2, 3);
        wr(3, 0);
        repeat (5) @(negedge clk);
        look("R8 idle pin holds", 2, 3, 0);
        pin_fall();
        look("R8 one fall", 2, 2, 0);
        pin_fall();
        look("R8 two falls", 2, 1, 0);
        look("R8 no flag yet", 6, 0, 0);
        pin_fall();
        look("R8 three falls", 2, 0, 0);
        look("R8 flag", 6, 2, 0);
        check("R10 B masked", irq, 0);
        wr(5, 3);
        check("R10 B enabled", irq, 1);

        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule